// File: doc/BRIEF.md
# Receive Count Capture on Chip-Select Release

This block sits next to a two-buffer (A/B) receive DMA of an SPI slave port. It watches the synchronized, active-low chip select for its release, which is a transition from low to high. On the first release after a receive buffer has been loaded, it copies the receive count of whichever buffer is currently active into a saved-count register. Software can then read how many bytes arrived in the transaction that just ended.

The block also keeps a 3-bit status word. The status tells which buffer the saved count came from, and whether chip select was released again after the capture. Loading either buffer clears the status and arms the block for a new capture. The saved count itself stays unchanged until the next capture.

Top module: `rx_cnt_capture`

## Requirements
- R1: After reset, `saved_cnt_o` is 0 and `status_o` is 3'b000. The block is disarmed: a release seen before the first buffer load changes neither output.
- R2: With the block armed and `active_b_i`=0, a release copies `cnt_a_i` into `saved_cnt_o` and sets `status_o` to 3'b001 (bit0 means the count came from buffer A).
- R3: With the block armed and `active_b_i`=1, a release copies `cnt_b_i` into `saved_cnt_o` and sets `status_o` to 3'b010 (bit1 means the count came from buffer B). Bits 0 and 1 of the status are never set together.
- R4: After a capture, further releases leave `saved_cnt_o` unchanged until another capture takes place, even when the buffer counts change in between.
- R5: A release that follows a capture with no buffer load in between sets `status_o` bit2. Bits 1:0 keep their value.
- R6: Asserting `load_a_i` or `load_b_i` clears `status_o` to 3'b000 on the next clock and re-arms the capture. `saved_cnt_o` keeps its value.
- R7: When a load and a release fall on the same clock, the load takes priority. No capture happens, and the block is armed afterwards.
- R8: A release is a cycle in which `cs_n_i` is sampled high after being sampled low on the previous clock. A high pulse lasting one cycle counts as a release, and chip select held high counts only once.
- R9: The capture uses the count and the `active_b_i` value sampled on the clock edge that detects the release. Both outputs show the result from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Synchronized chip select, active low |
| active_b_i | input | 1 | Active receive buffer: 0 = A, 1 = B |
| cnt_a_i | input | CNT_W | Receive count of buffer A |
| cnt_b_i | input | CNT_W | Receive count of buffer B |
| load_a_i | input | 1 | Buffer A load strobe |
| load_b_i | input | 1 | Buffer B load strobe |
| saved_cnt_o | output | CNT_W | Count captured on the first release |
| status_o | output | 3 | {extra release, saved from B, saved from A} |

## Verification
The directed patterns cover several cases. A release before any load shows that the reset state is disarmed. Releases with buffer A active and then with buffer B active show which count source is selected. Repeated releases, some with the counts changed, separate the first edge from later ones and show that the extra-edge bit is set. A load on the same clock as a release checks the priority between the two. Single-cycle pulses and chip select held high test the edge detector. A long pseudo-random phase then mixes all of these inputs and is compared cycle by cycle against a behavioural model.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef struct packed {
    logic extra;
    logic from_b;
    logic from_a;
  } rcc_status_t;
endpackage

// File: rtl/rcc_edge.sv
module rcc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  output logic rise_o
);
  logic cs_q;

  // reset to released so a high level after reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_n_i;
  end

  assign rise_o = cs_n_i & ~cs_q;
endmodule

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
  import rcc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rise_i,
  input  logic        load_i,
  input  logic        active_b_i,
  output logic        capture_o,
  output rcc_status_t status_o
);
  logic        armed_q;
  rcc_status_t status_q;

  assign capture_o = rise_i & armed_q & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      status_q <= '0;
    end else if (load_i) begin
      armed_q  <= 1'b1;
      status_q <= '0;
    end else if (capture_o) begin
      armed_q         <= 1'b0;
      status_q.from_a <= ~active_b_i;
      status_q.from_b <= active_b_i;
    end else if (rise_i && (status_q.from_a || status_q.from_b)) begin
      status_q.extra <= 1'b1;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/rcc_hold.sv
module rcc_hold #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             sel_b_i,
  input  logic [CNT_W-1:0] cnt_a_i,
  input  logic [CNT_W-1:0] cnt_b_i,
  output logic [CNT_W-1:0] saved_o
);
  logic [CNT_W-1:0] saved_q;
  logic [CNT_W-1:0] pick;

  assign pick = sel_b_i ? cnt_b_i : cnt_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        saved_q <= '0;
    else if (capture_i) saved_q <= pick;
  end

  assign saved_o = saved_q;
endmodule

// File: rtl/rx_cnt_capture.sv
module rx_cnt_capture
  import rcc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             active_b_i,
  input  logic [CNT_W-1:0] cnt_a_i,
  input  logic [CNT_W-1:0] cnt_b_i,
  input  logic             load_a_i,
  input  logic             load_b_i,
  output logic [CNT_W-1:0] saved_cnt_o,
  output logic [2:0]       status_o
);
  logic        rise;
  logic        capture;
  rcc_status_t status;

  rcc_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_n_i (cs_n_i),
    .rise_o (rise)
  );

  rcc_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .load_i     (load_a_i | load_b_i),
    .active_b_i (active_b_i),
    .capture_o  (capture),
    .status_o   (status)
  );

  rcc_hold #(.CNT_W(CNT_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .sel_b_i   (active_b_i),
    .cnt_a_i   (cnt_a_i),
    .cnt_b_i   (cnt_b_i),
    .saved_o   (saved_cnt_o)
  );

  assign status_o = status;
endmodule

// File: rtl/rx_cnt_capture_chk.sv
module rx_cnt_capture_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_n_i,
  input logic             active_b_i,
  input logic             load_a_i,
  input logic             load_b_i,
  input logic [CNT_W-1:0] saved_cnt_o,
  input logic [2:0]       status_o
);
  AST_SRC_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1:0] != 2'b11); // R3

  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_a_i || load_b_i) |=> (status_o == 3'b000)); // R6

  AST_HOLD_AFTER_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o[1:0] != 2'b00) && !load_a_i && !load_b_i) |=> $stable(saved_cnt_o)); // R4

  AST_EXTRA_NEEDS_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> (status_o[1:0] != 2'b00)); // R5

  AST_FROM_A_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> ($past(!active_b_i) && $past(cs_n_i))); // R2

  AST_FROM_B_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> ($past(active_b_i) && $past(cs_n_i))); // R3
endmodule

bind rx_cnt_capture rx_cnt_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_i      (cs_n_i),
  .active_b_i  (active_b_i),
  .load_a_i    (load_a_i),
  .load_b_i    (load_b_i),
  .saved_cnt_o (saved_cnt_o),
  .status_o    (status_o)
);

// File: tb/sim_rx_cnt_capture.sv
module sim_rx_cnt_capture;
  localparam int W = 16;

  logic clk = 0;
  logic rst_ni = 0;
  logic cs_n = 1, act_b = 0, ld_a = 0, ld_b = 0;
  logic [W-1:0] ca = 0, cb = 0;
  logic [W-1:0] saved;
  logic [2:0] status;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  // reference model state
  int m_prev, m_armed, m_saved, m_status;

  always #5 clk = ~clk;

  rx_cnt_capture #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n), .active_b_i(act_b),
    .cnt_a_i(ca), .cnt_b_i(cb), .load_a_i(ld_a), .load_b_i(ld_b),
    .saved_cnt_o(saved), .status_o(status)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_prev = 1; m_armed = 0; m_saved = 0; m_status = 0;
    end else begin
      int rise;
      rise = (cs_n == 1'b1 && m_prev == 0) ? 1 : 0;
      m_prev = int'(cs_n);
      if (ld_a || ld_b) begin
        m_status = 0; m_armed = 1;
      end else if (rise != 0) begin
        if (m_armed != 0) begin
          m_saved  = act_b ? int'(cb) : int'(ca);
          m_status = act_b ? 2 : 1;
          m_armed  = 0;
        end else if (m_status != 0) begin
          m_status = m_status | 4;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    check(tag, int'(saved), m_saved);
    check(tag, int'(status), m_status);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rel_pulse();  // low one cycle, then high one cycle
    cs_n = 0; step(); cs_n = 1; step();
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(2);
    check("R1", int'(saved), 0);
    check("R1", int'(status), 0);
    rst_ni = 1;
    step();
    // R1: release before any load is ignored
    tag = "R1"; ca = 16'h0011; rel_pulse(); step();
    check("R1", int'(status), 0);
    check("R1", int'(saved), 0);

    // R2: capture from A
    tag = "R2"; ld_a = 1; step(); ld_a = 0;
    ca = 16'h1234; cb = 16'h5678; act_b = 0;
    rel_pulse();
    check("R2", int'(saved), 16'h1234);
    check("R2", int'(status), 3'b001);

    // R4/R5: later releases with changed counts
    tag = "R4"; ca = 16'h9999; rel_pulse();
    check("R4", int'(saved), 16'h1234);
    check("R5", int'(status), 3'b101);

    // R6: load clears status, keeps saved
    tag = "R6"; ld_b = 1; step(); ld_b = 0;
    check("R6", int'(status), 0);
    check("R6", int'(saved), 16'h1234);

    // R3: capture from B
    tag = "R3"; act_b = 1; cb = 16'h00AB; rel_pulse();
    check("R3", int'(saved), 16'h00AB);
    check("R3", int'(status), 3'b010);

    // R7: load and release same cycle
    tag = "R7"; cs_n = 0; ld_a = 1; step(); ld_a = 0; step();
    cs_n = 1; ld_a = 1; cb = 16'h0F0F; step(); ld_a = 0;
    check("R7", int'(status), 0);
    check("R7", int'(saved), 16'h00AB);
    rel_pulse();
    check("R7", int'(saved), 16'h0F0F);

    // R8: held high gives one edge only
    tag = "R8"; ld_a = 1; step(); ld_a = 0; act_b = 0; ca = 16'h0042;
    cs_n = 0; step(); cs_n = 1; step(5);
    check("R8", int'(status), 3'b001);
    // R9: count sampled on the detecting edge, not later
    tag = "R9"; ld_b = 1; step(); ld_b = 0; ca = 16'h0777;
    cs_n = 0; step(); cs_n = 1; @(posedge clk); #1 ca = 16'h0888;
    step();
    check("R9", int'(saved), 16'h0777);

    // mixed pseudo-random phase
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cs_n  = (r < 45);
      ld_a  = (r >= 45 && r < 50);
      ld_b  = (r >= 50 && r < 54);
      act_b = $urandom_range(0, 1) == 1;
      ca    = W'($urandom);
      cb    = W'($urandom);
      step();
    end
    cs_n = 1; ld_a = 0; ld_b = 0;
    step(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule